// File: doc/BRIEF.md
# Sequential 64-by-32 Integer Divider

This block divides a 64-bit dividend by a 32-bit divisor and returns a 64-bit quotient. The divisor is the low half of a 64-bit operand port, and the upper half of that port is never used. A mode input selects the arithmetic. In unsigned mode both operands are plain magnitudes. In signed mode both are two's-complement values, and the quotient is truncated toward zero. No remainder is produced.

A request is a single-cycle `start` pulse, sampled on the rising clock edge while the block is idle. The block then runs a restoring division on the operand magnitudes and retires one quotient bit per cycle. In signed mode the sign of the quotient is fixed up on the last step.

Two operand combinations skip the loop and return the dividend unchanged in one cycle: a zero divisor, and the signed overflow case (most negative dividend divided by minus one). The quotient stays on `quotient` until the next completion. Each completion is marked by a one-cycle `done` pulse.

Top module: `wide_divider`

## Requirements
- R1: With `is_signed`=0, the quotient equals floor(`dividend` / `divisor_src[31:0]`), both taken as unsigned. `divisor_src[63:32]` has no effect.
- R2: With `is_signed`=1, both operands are two's complement (the divisor is 32 bits wide). The quotient is their exact quotient truncated toward zero, as a 64-bit two's-complement value.
- R3: When `divisor_src[31:0]` is zero, the result equals `dividend` in either mode.
- R4: With `is_signed`=1, `dividend`=0x8000_0000_0000_0000 and `divisor_src[31:0]`=0xFFFF_FFFF, the result equals `dividend`. With `is_signed`=0 the same operands divide normally.
- R5: For a zero-divisor or overflow request, `done` is high in the cycle right after the edge that samples `start`, and `busy` stays low.
- R6: For any other request, `busy` is high for exactly 64 cycles after the sampling edge. `done` is high in the cycle in which `busy` falls.
- R7: `start` is ignored while `busy` is high. A start pulse raised with different operands neither changes the running result nor adds a completion.
- R8: `done` is high for one cycle per accepted request, and `busy` and `done` are never high together.
- R9: After reset `busy` and `done` are low and `quotient` is zero.
- R10: `quotient` changes only on a completion and otherwise holds its value, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| start | input | 1 | Request strobe, accepted only while idle |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend | input | 64 | Dividend |
| divisor_src | input | 64 | Divisor in bits 31:0, bits 63:32 unused |
| busy | output | 1 | Division loop in progress |
| done | output | 1 | One-cycle completion strobe |
| quotient | output | 64 | Last result, held between completions |

## Verification
Random operands are drawn with a fixed seed from several divisor classes. Small divisors give long quotients. Full-width divisors and divisors with the top bit set separate the unsigned and signed readings of bit 31. Random upper halves of `divisor_src` show whether those bits leak into the result.

Directed cases cover both special paths in both modes, and the overflow operands in unsigned mode, where they must not be special. Dividend/divisor sign combinations confirm truncation toward zero rather than flooring. A start pulse during a run, and input changes while idle, show whether the running result or the held quotient can be disturbed.

// File: rtl/div_pkg.sv
package div_pkg;

  // Controller states of the sequential divider.
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;

endpackage

// File: rtl/div_prep.sv
// Operand preparation: magnitudes, quotient sign and special-case detection.
module div_prep #(
  parameter int AW = 64,
  parameter int BW = 32
) (
  input  logic          is_signed,
  input  logic [AW-1:0] a_in,
  input  logic [BW-1:0] b_in,
  output logic [AW-1:0] mag_a,
  output logic [BW-1:0] mag_b,
  output logic          q_neg,
  output logic          special
);

  localparam logic [AW-1:0] A_MIN = {1'b1, {(AW-1){1'b0}}};

  logic a_neg;
  logic b_neg;
  logic b_zero;
  logic s_ovf;

  always_comb begin
    a_neg   = is_signed & a_in[AW-1];
    b_neg   = is_signed & b_in[BW-1];
    mag_a   = a_neg ? (~a_in + {{(AW-1){1'b0}}, 1'b1}) : a_in;
    mag_b   = b_neg ? (~b_in + {{(BW-1){1'b0}}, 1'b1}) : b_in;
    q_neg   = a_neg ^ b_neg;
    b_zero  = (b_in == '0);
    s_ovf   = is_signed & (a_in == A_MIN) & (b_in == '1);
    special = b_zero | s_ovf;
  end

endmodule

// File: rtl/div_step.sv
// One restoring-division step: shifts in the next dividend bit and
// subtracts the divisor when the trial value is large enough.
module div_step #(
  parameter int AW = 64,
  parameter int BW = 32
) (
  input  logic [BW-1:0] rem_in,
  input  logic [AW-1:0] qr_in,
  input  logic [BW-1:0] dvs,
  output logic [BW-1:0] rem_out,
  output logic [AW-1:0] qr_out
);

  logic [BW:0] trial;
  logic [BW:0] diff;
  logic        qbit;

  always_comb begin
    trial   = {rem_in, qr_in[AW-1]};
    diff    = trial - {1'b0, dvs};
    qbit    = ~diff[BW];
    rem_out = qbit ? diff[BW-1:0] : trial[BW-1:0];
    qr_out  = {qr_in[AW-2:0], qbit};
  end

endmodule

// File: rtl/div_fix.sv
// Applies the quotient sign after the magnitude loop.
module div_fix #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] q_mag,
  input  logic          neg,
  output logic [AW-1:0] q_out
);

  always_comb begin
    q_out = neg ? (~q_mag + {{(AW-1){1'b0}}, 1'b1}) : q_mag;
  end

endmodule

// File: rtl/wide_divider.sv
module wide_divider
  import div_pkg::*;
#(
  parameter int AW = 64,
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_signed,
  input  logic [AW-1:0] dividend,
  input  logic [AW-1:0] divisor_src,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] quotient
);

  localparam int CW = $clog2(AW);
  localparam logic [CW-1:0] LAST = CW'(AW - 1);

  // Registers
  div_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] rem_q;
  logic [AW-1:0] qr_q;
  logic [BW-1:0] dvs_q;
  logic          neg_q;
  logic [AW-1:0] quot_q;
  logic          done_q;

  // Next-state values
  div_state_e    state_d;
  logic [CW-1:0] cnt_d;
  logic [BW-1:0] rem_d;
  logic [AW-1:0] qr_d;
  logic [BW-1:0] dvs_d;
  logic          neg_d;
  logic [AW-1:0] quot_d;
  logic          done_d;
  logic          work_en;
  logic          quot_en;

  // Combinational datapath
  logic [AW-1:0] p_mag_a;
  logic [BW-1:0] p_mag_b;
  logic          p_neg;
  logic          p_special;
  logic [BW-1:0] s_rem;
  logic [AW-1:0] s_qr;
  logic [AW-1:0] f_q;
  logic          accept;
  logic          last_step;

  div_prep #(.AW(AW), .BW(BW)) u_prep (
    .is_signed (is_signed),
    .a_in      (dividend),
    .b_in      (divisor_src[BW-1:0]),
    .mag_a     (p_mag_a),
    .mag_b     (p_mag_b),
    .q_neg     (p_neg),
    .special   (p_special)
  );

  div_step #(.AW(AW), .BW(BW)) u_step (
    .rem_in  (rem_q),
    .qr_in   (qr_q),
    .dvs     (dvs_q),
    .rem_out (s_rem),
    .qr_out  (s_qr)
  );

  div_fix #(.AW(AW)) u_fix (
    .q_mag (s_qr),
    .neg   (neg_q),
    .q_out (f_q)
  );

  assign accept    = start & (state_q == ST_IDLE);
  assign last_step = (state_q == ST_RUN) & (cnt_q == LAST);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    qr_d    = qr_q;
    dvs_d   = dvs_q;
    neg_d   = neg_q;
    quot_d  = quot_q;
    done_d  = 1'b0;
    work_en = 1'b0;
    quot_en = 1'b0;
    if (accept) begin
      if (p_special) begin
        quot_d  = dividend;
        quot_en = 1'b1;
        done_d  = 1'b1;
      end else begin
        state_d = ST_RUN;
        cnt_d   = '0;
        rem_d   = '0;
        qr_d    = p_mag_a;
        dvs_d   = p_mag_b;
        neg_d   = p_neg;
        work_en = 1'b1;
      end
    end else if (state_q == ST_RUN) begin
      work_en = 1'b1;
      cnt_d   = cnt_q + {{(CW-1){1'b0}}, 1'b1};
      rem_d   = s_rem;
      qr_d    = s_qr;
      if (last_step) begin
        state_d = ST_IDLE;
        quot_d  = f_q;
        quot_en = 1'b1;
        done_d  = 1'b1;
      end
    end
  end

  // Registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rem_q <= '0;
      qr_q  <= '0;
      dvs_q <= '0;
      neg_q <= 1'b0;
    end else if (work_en) begin
      cnt_q <= cnt_d;
      rem_q <= rem_d;
      qr_q  <= qr_d;
      dvs_q <= dvs_d;
      neg_q <= neg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot_q <= '0;
    end else if (quot_en) begin
      quot_q <= quot_d;
    end
  end

  assign busy     = (state_q == ST_RUN);
  assign done     = done_q;
  assign quotient = quot_q;

  // Assertions
  a_r3_zero_returns_a: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor_src[BW-1:0] == '0) |=> (quotient == $past(dividend)));

  a_r5_special_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && p_special) |=> (done && !busy));

  a_r6_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r6_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != LAST) |=> busy);

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt_q != LAST) |=> (busy && $stable(dvs_q) && $stable(neg_q)));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(quotient));

endmodule

// File: tb/wide_divider_test.sv
module wide_divider_test;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        is_signed;
  logic [63:0] dividend;
  logic [63:0] divisor_src;
  logic        busy;
  logic        done;
  logic [63:0] quotient;

  int tests;
  int fails;
  int cycles;

  wide_divider uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .is_signed   (is_signed),
    .dividend    (dividend),
    .divisor_src (divisor_src),
    .busy        (busy),
    .done        (done),
    .quotient    (quotient)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 190000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [63:0] ref_q(bit sm, logic [63:0] a, logic [63:0] b);
    logic [31:0] d;
    longint sa;
    longint sd;
    d = b[31:0];
    if (d == 32'd0) return a;
    if (!sm) return a / {32'd0, d};
    if (a == 64'h8000_0000_0000_0000 && d == 32'hFFFF_FFFF) return a;
    sa = longint'(a);
    sd = longint'(int'(d));
    return 64'(sa / sd);
  endfunction

  function automatic bit is_special(bit sm, logic [63:0] a, logic [63:0] b);
    return (b[31:0] == 32'd0) ||
           (sm && a == 64'h8000_0000_0000_0000 && b[31:0] == 32'hFFFF_FFFF);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue one request and check result, latency and busy behaviour.
  task automatic run_op(string req, bit sm, logic [63:0] a, logic [63:0] b);
    int k;
    bit sp;
    logic [63:0] exp;
    exp = ref_q(sm, a, b);
    sp  = is_special(sm, a, b);
    @(negedge clk);
    start = 1'b1; is_signed = sm; dividend = a; divisor_src = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    dividend = 64'hDEAD_BEEF_0BAD_F00D; divisor_src = 64'h1234_5678_0000_0003;
    check(sp ? "R5 busy low" : "R6 busy high", {63'd0, busy}, {63'd0, !sp});
    k = 0;
    while (!done && k < 200) begin
      @(posedge clk);
      @(negedge clk);
      k++;
    end
    check(req, quotient, exp);
    check(sp ? "R5 latency" : "R6 latency", 64'(k), sp ? 64'd0 : 64'd64);
    check("R8 busy with done", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    tests = 0; fails = 0; cycles = 0;
    rst_n = 1'b0; start = 1'b0; is_signed = 1'b0;
    dividend = '0; divisor_src = '0;
    repeat (3) @(negedge clk);
    check("R9 busy", {63'd0, busy}, 64'd0);
    check("R9 done", {63'd0, done}, 64'd0);
    check("R9 quotient", quotient, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corner cases
    run_op("R1 basic", 1'b0, 64'd100, 64'd7);
    run_op("R1 upper half ignored", 1'b0, 64'd1000, 64'hFFFF_FFFF_0000_000A);
    run_op("R1 full divisor", 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF);
    run_op("R1 divisor one", 1'b0, 64'hFEDC_BA98_7654_3210, 64'd1);
    run_op("R2 neg/pos", 1'b1, -64'sd7, 64'd2);
    run_op("R2 pos/neg", 1'b1, 64'd7, 64'h0000_0000_FFFF_FFFE);
    run_op("R2 neg/neg", 1'b1, -64'sd7, 64'h0000_0000_FFFF_FFFE);
    run_op("R2 min/one", 1'b1, 64'h8000_0000_0000_0000, 64'd1);
    run_op("R2 min/min32", 1'b1, 64'h8000_0000_0000_0000, 64'h0000_0000_8000_0000);
    run_op("R3 zero unsigned", 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_0000_0000);
    run_op("R3 zero signed", 1'b1, 64'h8123_4567_89AB_CDEF, 64'd0);
    run_op("R4 overflow signed", 1'b1, 64'h8000_0000_0000_0000, 64'h0000_0000_FFFF_FFFF);
    run_op("R4 same operands unsigned", 1'b0, 64'h8000_0000_0000_0000, 64'h0000_0000_FFFF_FFFF);

    // R7: start raised mid-run with other operands
    begin
      int pulses;
      @(negedge clk);
      start = 1'b1; is_signed = 1'b0; dividend = 64'd1_000_000; divisor_src = 64'd10;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      start = 1'b1; is_signed = 1'b1; dividend = 64'd77; divisor_src = 64'd0;
      @(negedge clk);
      start = 1'b0;
      pulses = 0;
      for (int i = 0; i < 70; i++) begin
        if (done) begin
          pulses++;
          check("R7 running result kept", quotient, 64'd100_000);
        end
        @(negedge clk);
      end
      check("R7 single completion", 64'(pulses), 64'd1);
    end

    // R8 / R10: done drops, quotient holds while inputs move
    begin
      logic [63:0] held;
      run_op("R1 before hold", 1'b0, 64'd81, 64'd9);
      held = quotient;
      @(negedge clk);
      check("R8 done one cycle", {63'd0, done}, 64'd0);
      for (int i = 0; i < 5; i++) begin
        dividend = 64'(i * 12345); divisor_src = 64'(i);
        @(negedge clk);
      end
      check("R10 quotient held", quotient, held);
    end

    // Constrained random
    void'($urandom(32'd2024));
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a;
      logic [63:0] b;
      bit sm;
      int cls;
      a   = {$urandom(), $urandom()};
      sm  = $urandom() % 2;
      cls = $urandom() % 5;
      case (cls)
        0: b = {$urandom(), 32'($urandom() % 16)};
        1: b = {$urandom(), $urandom()};
        2: b = {$urandom(), 1'b1, 31'($urandom())};
        3: b = {$urandom(), 32'd0};
        default: b = {32'd0, 32'($urandom() % 1000) + 32'd1};
      endcase
      if (cls == 4) a = a >> ($urandom() % 64);
      run_op(sm ? "R2 random signed" : "R1 random unsigned", sm, a, b);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule